// File: doc/BRIEF.md
# Single-Level Page Translation Unit

The unit turns a logical address from a processor into a physical address by looking it up in a small page table kept in registers. The upper bits of the logical address select a table entry. The lower bits are the offset inside the page, and they pass through unchanged. Each entry holds a frame number, a valid flag and a read-only flag. A good lookup returns the frame number placed above the offset. If the entry is invalid, or a write targets a read-only page, the unit raises a trap with a cause code and returns no address.

Supervisor software fills the table through a separate configuration port, one entry per cycle. Translation takes exactly one clock cycle: a request presented in one cycle is answered in the next. The logical width, the offset width and the frame-number width are parameters. The default is a 16-byte logical space of 4-byte pages, mapped onto 8 frames (32 bytes of physical memory).

Top module: `page_xlate_unit`

## Requirements
- R1: After reset, every table entry is invalid and `rsp_valid` is low. A lookup of any page before the first configuration write therefore traps with cause 1.
- R2: The page number is `req_laddr[LA_W-1:OFS_W]` and the offset is `req_laddr[OFS_W-1:0]`. The offset appears unchanged in `rsp_paddr[OFS_W-1:0]` of every response that does not trap.
- R3: A response that does not trap carries `rsp_paddr = {frame, offset}`, where frame is the frame number stored for that page.
- R4: `rsp_valid` is high in the cycle after each cycle in which `req_valid` is high, and low otherwise.
- R5: A lookup of a page whose valid flag is clear traps with cause 1 (invalid). This check takes priority over the protection check.
- R6: A write (`req_write`=1) to a valid page marked read-only traps with cause 2 (protection). A read (`req_write`=0) of the same page succeeds.
- R7: Reads and writes to a valid page that is not read-only succeed with cause 0.
- R8: A configuration write changes the entry from the next cycle on. A lookup in the same cycle as the write sees the old entry.
- R9: `rsp_trap` is high exactly when `rsp_cause` is not 0. A trapping response carries `rsp_paddr` = 0.
- R10: A configuration write with `cfg_valid`=0 invalidates the entry, and later lookups of that page trap with cause 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_laddr | input | LA_W | Logical address |
| cfg_we | input | 1 | Write one page-table entry |
| cfg_page | input | LA_W-OFS_W | Entry index to write |
| cfg_frame | input | FRAME_W | Frame number for the entry |
| cfg_valid | input | 1 | Valid flag for the entry |
| cfg_ro | input | 1 | Read-only flag for the entry |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_paddr | output | FRAME_W+OFS_W | Physical address, 0 on trap |
| rsp_trap | output | 1 | Access trapped |
| rsp_cause | output | 2 | 0 none, 1 invalid page, 2 protection |

## Verification
The assertions assume that `req_valid` is low during reset. If it were high at the last reset edge, the one-cycle relation between request and response could not hold in the first cycle after reset. The bench therefore holds every input at zero while reset is asserted. It also drives all inputs once per cycle at the falling edge, so no request or configuration value changes near a rising edge. Expected responses come from a model table kept in the bench. In cycles that both write and look up, the model computes the expected response from the old entry before applying the write.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_INVALID = 2'd1,
        CAUSE_PROT    = 2'd2
    } cause_e;

endpackage

// File: rtl/pxu_table.sv
module pxu_table #(
    parameter int PN_W    = 2,
    parameter int FRAME_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [PN_W-1:0]    cfg_page,
    input  logic [FRAME_W-1:0] cfg_frame,
    input  logic               cfg_valid,
    input  logic               cfg_ro,
    input  logic [PN_W-1:0]    lk_page,
    output logic               lk_valid,
    output logic               lk_ro,
    output logic [FRAME_W-1:0] lk_frame
);

    localparam int PAGES = 1 << PN_W;

    typedef struct packed {
        logic [PAGES-1:0]              vld;
        logic [PAGES-1:0]              ro;
        logic [PAGES-1:0][FRAME_W-1:0] frm;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic [PAGES-1:0] hit;

    // Per-entry write decode
    for (genvar g = 0; g < PAGES; g++) begin : g_dec
        assign hit[g] = cfg_we && (cfg_page == PN_W'(g));
    end

    always_comb begin
        tbl_d = tbl_q;
        for (int i = 0; i < PAGES; i++) begin
            if (hit[i]) begin
                tbl_d.vld[i] = cfg_valid;
                tbl_d.ro[i]  = cfg_ro;
                tbl_d.frm[i] = cfg_frame;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    // Lookup reads the registered table: a same-cycle write is not seen
    assign lk_valid = tbl_q.vld[lk_page];
    assign lk_ro    = tbl_q.ro[lk_page];
    assign lk_frame = tbl_q.frm[lk_page];

endmodule

// File: rtl/pxu_check.sv
module pxu_check
    import pxu_pkg::*;
#(
    parameter int OFS_W   = 2,
    parameter int FRAME_W = 3
) (
    input  logic                     ent_valid,
    input  logic                     ent_ro,
    input  logic [FRAME_W-1:0]       ent_frame,
    input  logic                     is_write,
    input  logic [OFS_W-1:0]         offset,
    output cause_e                   cause,
    output logic [FRAME_W+OFS_W-1:0] paddr
);

    always_comb begin
        cause = CAUSE_NONE;
        paddr = {ent_frame, offset};
        if (!ent_valid) begin
            cause = CAUSE_INVALID;
            paddr = '0;
        end else if (is_write && ent_ro) begin
            cause = CAUSE_PROT;
            paddr = '0;
        end
    end

endmodule

// File: rtl/page_xlate_unit.sv
module page_xlate_unit
    import pxu_pkg::*;
#(
    parameter int LA_W    = 4,
    parameter int OFS_W   = 2,
    parameter int FRAME_W = 3,
    localparam int PN_W   = LA_W - OFS_W,
    localparam int PA_W   = FRAME_W + OFS_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [LA_W-1:0]    req_laddr,
    input  logic               cfg_we,
    input  logic [PN_W-1:0]    cfg_page,
    input  logic [FRAME_W-1:0] cfg_frame,
    input  logic               cfg_valid,
    input  logic               cfg_ro,
    output logic               rsp_valid,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic               rsp_trap,
    output logic [1:0]         rsp_cause
);

    typedef struct packed {
        logic            vld;
        logic [PA_W-1:0] pa;
        cause_e          cause;
    } out_t;

    out_t out_d, out_q;

    logic [PN_W-1:0]    page_num;
    logic [OFS_W-1:0]   page_ofs;
    logic               ent_valid;
    logic               ent_ro;
    logic [FRAME_W-1:0] ent_frame;
    cause_e             chk_cause;
    logic [PA_W-1:0]    chk_paddr;

    assign page_num = req_laddr[LA_W-1:OFS_W];
    assign page_ofs = req_laddr[OFS_W-1:0];

    pxu_table #(
        .PN_W    (PN_W),
        .FRAME_W (FRAME_W)
    ) i_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_page  (cfg_page),
        .cfg_frame (cfg_frame),
        .cfg_valid (cfg_valid),
        .cfg_ro    (cfg_ro),
        .lk_page   (page_num),
        .lk_valid  (ent_valid),
        .lk_ro     (ent_ro),
        .lk_frame  (ent_frame)
    );

    pxu_check #(
        .OFS_W   (OFS_W),
        .FRAME_W (FRAME_W)
    ) i_check (
        .ent_valid (ent_valid),
        .ent_ro    (ent_ro),
        .ent_frame (ent_frame),
        .is_write  (req_write),
        .offset    (page_ofs),
        .cause     (chk_cause),
        .paddr     (chk_paddr)
    );

    always_comb begin
        out_d       = '0;
        out_d.cause = CAUSE_NONE;
        if (req_valid) begin
            out_d.vld   = 1'b1;
            out_d.pa    = chk_paddr;
            out_d.cause = chk_cause;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rsp_valid = out_q.vld;
    assign rsp_paddr = out_q.pa;
    assign rsp_cause = out_q.cause;
    assign rsp_trap  = (out_q.cause != CAUSE_NONE);

endmodule

// File: rtl/pxu_checker.sv
module pxu_checker #(
    parameter int LA_W    = 4,
    parameter int OFS_W   = 2,
    parameter int FRAME_W = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic                     req_write,
    input logic [LA_W-1:0]          req_laddr,
    input logic                     rsp_valid,
    input logic [FRAME_W+OFS_W-1:0] rsp_paddr,
    input logic                     rsp_trap,
    input logic [1:0]               rsp_cause
);

    assert_rsp_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_valid));

    assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_trap) |-> rsp_paddr[OFS_W-1:0] == $past(req_laddr[OFS_W-1:0]));

    assert_trap_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap == (rsp_cause != 2'd0));

    assert_trap_zero_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_trap |-> rsp_paddr == '0);

    assert_read_no_prot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !$past(req_write)) |-> rsp_cause != 2'd2);

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_trap);

    assert_cause_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_cause != 2'd3);

endmodule

bind page_xlate_unit pxu_checker #(
    .LA_W    (LA_W),
    .OFS_W   (OFS_W),
    .FRAME_W (FRAME_W)
) i_pxu_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_laddr (req_laddr),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_trap  (rsp_trap),
    .rsp_cause (rsp_cause)
);

// File: tb/test_page_xlate_unit.sv
`timescale 1ns/1ps
module test_page_xlate_unit;

    localparam int LA_W = 4, OFS_W = 2, FRAME_W = 3;
    localparam int PN_W = LA_W - OFS_W, PA_W = FRAME_W + OFS_W;
    localparam int PAGES = 1 << PN_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_write = 0;
    logic [LA_W-1:0] req_laddr = '0;
    logic cfg_we = 0, cfg_valid = 0, cfg_ro = 0;
    logic [PN_W-1:0] cfg_page = '0;
    logic [FRAME_W-1:0] cfg_frame = '0;
    logic rsp_valid, rsp_trap;
    logic [PA_W-1:0] rsp_paddr;
    logic [1:0] rsp_cause;

    int checks = 0, fails = 0;

    // Model table
    bit               m_vld [PAGES];
    bit               m_ro  [PAGES];
    bit [FRAME_W-1:0] m_frm [PAGES];

    // Scoreboard: one item per driven cycle
    bit               q_vld [$];
    bit [PA_W-1:0]    q_pa  [$];
    bit [1:0]         q_cs  [$];
    string            q_tag [$];

    always #2.5 clk = ~clk;

    page_xlate_unit #(.LA_W(LA_W), .OFS_W(OFS_W), .FRAME_W(FRAME_W)) i_page_xlate_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_laddr(req_laddr), .cfg_we(cfg_we), .cfg_page(cfg_page),
        .cfg_frame(cfg_frame), .cfg_valid(cfg_valid), .cfg_ro(cfg_ro),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_trap(rsp_trap),
        .rsp_cause(rsp_cause)
    );

    task automatic step(input bit rq, input bit wr, input bit [LA_W-1:0] la,
                        input bit cw, input bit [PN_W-1:0] cp, input bit [FRAME_W-1:0] cf,
                        input bit cv, input bit cr, input string tag);
        bit [PN_W-1:0] pg;
        bit [1:0] cs;
        bit [PA_W-1:0] pa;
        @(negedge clk);
        req_valid = rq; req_write = wr; req_laddr = la;
        cfg_we = cw; cfg_page = cp; cfg_frame = cf; cfg_valid = cv; cfg_ro = cr;
        pg = la[LA_W-1:OFS_W];
        cs = 2'd0;
        pa = {m_frm[pg], la[OFS_W-1:0]};
        if (!m_vld[pg]) begin cs = 2'd1; pa = '0; end
        else if (wr && m_ro[pg]) begin cs = 2'd2; pa = '0; end
        if (!rq) begin cs = 2'd0; pa = '0; end
        q_vld.push_back(rq); q_pa.push_back(pa); q_cs.push_back(cs); q_tag.push_back(tag);
        if (cw) begin m_vld[cp] = cv; m_ro[cp] = cr; m_frm[cp] = cf; end
    endtask

    task automatic rd(input bit [LA_W-1:0] la, input string tag);
        step(1, 0, la, 0, '0, '0, 0, 0, tag);
    endtask
    task automatic wr(input bit [LA_W-1:0] la, input string tag);
        step(1, 1, la, 0, '0, '0, 0, 0, tag);
    endtask
    task automatic cfg(input bit [PN_W-1:0] p, input bit [FRAME_W-1:0] f,
                       input bit v, input bit r, input string tag);
        step(0, 0, '0, 1, p, f, v, r, tag);
    endtask
    task automatic idle(input string tag);
        step(0, 0, '0, 0, '0, '0, 0, 0, tag);
    endtask

    // Monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                if (q_vld.size() != 0) begin
                    bit ev; bit [PA_W-1:0] ep; bit [1:0] ec; string t;
                    ev = q_vld.pop_front(); ep = q_pa.pop_front();
                    ec = q_cs.pop_front(); t = q_tag.pop_front();
                    checks++;
                    if (rsp_valid !== ev || (ev && (rsp_paddr !== ep || rsp_cause !== ec ||
                        rsp_trap !== (ec != 0))) || (!ev && rsp_trap !== 1'b0)) begin
                        fails++;
                        $display("FAIL %s: got v=%0b pa=%0h cause=%0d trap=%0b, expected v=%0b pa=%0h cause=%0d trap=%0b",
                                 t, rsp_valid, rsp_paddr, rsp_cause, rsp_trap, ev, ep, ec, (ec != 0));
                    end
                end else if (rsp_valid !== 1'b0) begin
                    checks++; fails++;
                    $display("FAIL R4: got rsp_valid=%0b, expected 0", rsp_valid);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < PAGES; i++) begin m_vld[i] = 0; m_ro[i] = 0; m_frm[i] = '0; end
        repeat (4) @(posedge clk);
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: got rsp_valid=%0b in reset, expected 0", rsp_valid);
        end
        rst_n = 1'b1;

        // R1: all pages invalid after reset
        for (int p = 0; p < PAGES; p++) rd(LA_W'(p * 4 + 1), "R1");
        idle("R4");

        // Fill table
        cfg(0, 3'd5, 1, 0, "R8");
        cfg(1, 3'd2, 1, 1, "R8");
        cfg(2, 3'd7, 1, 0, "R8");
        cfg(3, 3'd0, 0, 0, "R8");

        // R2/R3/R7: translation across offsets and pages
        for (int o = 0; o < 4; o++) rd(LA_W'(o), "R2");
        rd(4'b1011, "R3");
        wr(4'b0010, "R7");
        wr(4'b1001, "R7");
        // R6: read-only page
        rd(4'b0111, "R6");
        wr(4'b0110, "R6");
        // R5: invalid page, write as well (invalid wins)
        rd(4'b1100, "R5");
        wr(4'b1111, "R5");
        idle("R4");
        rd(4'b0001, "R4");
        idle("R4");

        // R8: same-cycle write and lookup sees old entry
        step(1, 0, 4'b1110, 1, 2'd3, 3'd4, 1, 1, "R8");
        rd(4'b1110, "R8");
        wr(4'b1101, "R8");
        step(1, 1, 4'b0100, 1, 2'd1, 3'd6, 1, 0, "R8");
        wr(4'b0100, "R8");

        // R10: invalidate page 2
        cfg(2, 3'd1, 0, 0, "R10");
        rd(4'b1000, "R10");
        wr(4'b1010, "R10");
        // R9: back-to-back mix of trap and no trap
        wr(4'b1111, "R9");
        rd(4'b0011, "R9");
        rd(4'b1001, "R9");
        idle("R9");
        idle("R9");

        @(posedge clk); #2;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule